// File: doc/BRIEF.md
# Slow-Clock Reset Sequencer

This block produces the active-low reset lines for a processor, its watchdog and its peripheral set, and it controls an open-drain reset pin shared with the board. Everything runs on a slow, always-on clock. A low level on the reset pin from outside the chip counts as a user reset. The internal lines are asserted, and the block also pulls the pin low for a programmable stretch so that the pulse is long enough for everything on the board. The lines are released only after the pin is seen high again and a short startup delay has passed.

Software can also ask for resets through a keyed command register: a processor pulse (which also resets the watchdog), a peripheral pulse (which also clears the memory-remap state held in the peripheral domain), and a stretched pulse on the external pin. These can be requested alone or together in one write. A three-bit status field records whether the last completed reset that reached the processor was a user reset or a software one.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no handshake because every access completes in the cycle it is presented.

Top module: `slowclk_rst_ctrl`

## Requirements
- R1: After the power-on input `por_n` is released, the reset outputs are high, the pin is not pulled, the status reads type 0, busy 0, NRST level 1, and the stretch code reads 0.
- R2: A write to address 0 is a command only when bits [31:24] equal 8'hA5. With any other key value, the write changes no output and no status.
- R3: In a keyed command, bit 0 requests a processor+watchdog pulse, bit 1 a peripheral pulse and bit 2 an external pin pulse. Any combination is served in one sequence. A keyed write with all three bits clear does nothing.
- R4: Processor and peripheral pulses are low for exactly 2 clock cycles, starting the cycle after the write is sampled.
- R5: The external pin is pulled low for 2^(L+1) cycles, where L is the stretch code held in bits [3:0] of address 1. This holds for both software and user resets.
- R6: Status bit 8 (busy) is 1 while a software sequence runs. When the pin was pulsed, busy stays 1 until the resynchronized pin level is high again. Command writes sampled while busy are ignored.
- R7: The pin level passes through two flip-flops before it is used. A pin that goes low is acted on by the third clock edge, and the internal resets and the pin pull go low after that edge.
- R8: During a user reset, the internal resets stay low as long as the pin is low, whether it is held by the stretch or by an outside driver. They rise 4 cycles after the pin is high: 2 for resynchronization and 2 for startup.
- R9: Status bits [2:0] become 4 when a user reset releases the processor, and 3 when a software processor pulse ends. Peripheral-only and pin-only commands leave the field unchanged.
- R10: If a user reset is detected in the same cycle as a keyed command write, the user reset is taken and the write is discarded.
- R11: Status bit 16 reads the resynchronized pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 command, 1 stretch code, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| nrst_pin_i | input | 1 | Sensed level of the open-drain reset pin |
| nrst_pull_o | output | 1 | 1 pulls the reset pin low |
| proc_rst_n | output | 1 | Processor reset, active low |
| wdt_rst_n | output | 1 | Watchdog reset, active low |
| periph_rst_n | output | 1 | Peripheral and remap reset, active low |

## Verification
A user reset detection and a keyed command write can land on the same clock edge. Both want to move the idle sequencer, and only the user reset may win. The bench provokes this by lowering the pin and then placing a processor command write so that it is sampled exactly on the edge where the resynchronized low first reaches the sequencer. It then judges the outcome cycle by cycle against a user-only reset profile. It also reads back a status type of 4 rather than 3, which shows that no software processor pulse was folded in.

// File: rtl/rcx_pkg.sv
package rcx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_USTRETCH,
    ST_UWAIT,
    ST_USTART,
    ST_SW
  } rc_state_e;

  typedef struct packed {
    logic ext;
    logic per;
    logic proc;
  } rc_cmd_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [7:0] CMD_KEY   = 8'hA5;
  localparam logic [2:0] TYPE_SW   = 3'd3;
  localparam logic [2:0] TYPE_USER = 3'd4;

endpackage

// File: rtl/rcx_sync.sv
module rcx_sync (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [1:0] ff_q;
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ff_q   <= 2'b11;
      warm_q <= 2'd0;
    end else begin
      ff_q <= {ff_q[0], pin_i};
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign lvl_o = ff_q[1];

  // R7: two-stage delay of the pin level
  a_r7_two_stage: assert property (@(posedge clk) disable iff (!por_n)
    (warm_q == 2'd2) |-> (lvl_o == $past(pin_i, 2)));

endmodule

// File: rtl/rcx_regs.sv
module rcx_regs
  import rcx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             nrst_lvl,
  input  logic             busy,
  input  logic             usr_done,
  input  logic             swproc_done,
  output logic             cmd_stb,
  output rc_cmd_t          cmd,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] len_q;
  logic [2:0]       type_q;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[23:LEN_W];
  assign cmd     = rc_cmd_t'(bus_wdata[2:0]);
  assign cmd_stb = bus_wr && (bus_addr == ADDR_CMD) &&
                   (bus_wdata[31:24] == CMD_KEY) && (|bus_wdata[2:0]);
  assign len     = len_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      len_q  <= '0;
      type_q <= 3'd0;
    end else begin
      if (bus_wr && bus_addr == ADDR_MODE) len_q <= bus_wdata[LEN_W-1:0];
      if (usr_done)         type_q <= TYPE_USER;
      else if (swproc_done) type_q <= TYPE_SW;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_MODE: bus_rdata[LEN_W-1:0] = len_q;
      ADDR_STAT: begin
        bus_rdata[2:0] = type_q;
        bus_rdata[8]   = busy;
        bus_rdata[16]  = nrst_lvl;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R9: type codes follow the completion events
  a_r9_user_code: assert property (@(posedge clk) disable iff (!por_n)
    usr_done |=> (type_q == TYPE_USER));
  a_r9_sw_code: assert property (@(posedge clk) disable iff (!por_n)
    swproc_done |=> (type_q == TYPE_SW));

endmodule

// File: rtl/rcx_seq.sv
module rcx_seq
  import rcx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             nrst_lvl,
  input  logic             cmd_stb,
  input  rc_cmd_t          cmd,
  input  logic [LEN_W-1:0] len,
  output logic             proc_rst_n,
  output logic             periph_rst_n,
  output logic             wdt_rst_n,
  output logic             nrst_drive,
  output logic             busy,
  output logic             usr_done,
  output logic             swproc_done
);
  localparam int CNT_W = 1 << LEN_W;

  rc_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stretch_m1;
  logic             p_proc_q, p_per_q, pcnt_q, ext_on_q, ext_wait_q;
  logic             in_usr, sw_proc_act, sw_per_act, pulse_end, ext_end;

  always_comb stretch_m1 = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(len));

  assign in_usr      = (state_q == ST_USTRETCH) || (state_q == ST_UWAIT) ||
                       (state_q == ST_USTART);
  assign sw_proc_act = (state_q == ST_SW) && p_proc_q;
  assign sw_per_act  = (state_q == ST_SW) && p_per_q;
  assign pulse_end   = !(p_proc_q || p_per_q) || !pcnt_q;
  assign ext_end     = !ext_on_q || (ext_wait_q && nrst_lvl);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      p_proc_q   <= 1'b0;
      p_per_q    <= 1'b0;
      pcnt_q     <= 1'b0;
      ext_on_q   <= 1'b0;
      ext_wait_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!nrst_lvl) begin
            state_q <= ST_USTRETCH;
            cnt_q   <= stretch_m1;
          end else if (cmd_stb) begin
            state_q    <= ST_SW;
            cnt_q      <= stretch_m1;
            p_proc_q   <= cmd.proc;
            p_per_q    <= cmd.per;
            pcnt_q     <= 1'b1;
            ext_on_q   <= cmd.ext;
            ext_wait_q <= 1'b0;
          end
        end
        ST_USTRETCH: begin
          if (cnt_q == '0) state_q <= ST_UWAIT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_UWAIT: begin
          if (nrst_lvl) begin
            state_q <= ST_USTART;
            cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end
        ST_USTART: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_SW: begin
          if (p_proc_q || p_per_q) begin
            if (pcnt_q) pcnt_q <= 1'b0;
            else begin
              p_proc_q <= 1'b0;
              p_per_q  <= 1'b0;
            end
          end
          if (ext_on_q) begin
            if (!ext_wait_q) begin
              if (cnt_q == '0) ext_wait_q <= 1'b1;
              else             cnt_q      <= cnt_q - 1'b1;
            end else if (nrst_lvl) begin
              ext_on_q <= 1'b0;
            end
          end
          if (pulse_end && ext_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign proc_rst_n   = !(in_usr || sw_proc_act);
  assign wdt_rst_n    = !(in_usr || sw_proc_act);
  assign periph_rst_n = !(in_usr || sw_per_act);
  assign nrst_drive   = (state_q == ST_USTRETCH) ||
                        ((state_q == ST_SW) && ext_on_q && !ext_wait_q);
  assign busy         = (state_q == ST_SW);
  assign usr_done     = (state_q == ST_USTART) && (cnt_q == '0);
  assign swproc_done  = sw_proc_act && !pcnt_q;

  // R4: a software processor pulse is exactly two cycles wide
  a_r4_pulse_two: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sw_proc_act) |=> sw_proc_act ##1 !sw_proc_act);
  // R6: a pulse can only start from the idle state, never while busy
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sw_proc_act) |-> ($past(state_q) == ST_IDLE));
  // R8: held pin keeps the user reset waiting
  a_r8_hold: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_UWAIT && !nrst_lvl) |=> (state_q == ST_UWAIT));
  // R8: two startup cycles after the pin is seen high
  a_r8_startup: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_UWAIT && nrst_lvl) |=>
      (state_q == ST_USTART) ##1 (state_q == ST_USTART) ##1 (state_q == ST_IDLE));
  // R10: a low pin seen in idle always starts a user reset
  a_r10_user_first: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_IDLE && !nrst_lvl) |=> (state_q == ST_USTRETCH));

endmodule

// File: rtl/slowclk_rst_ctrl.sv
module slowclk_rst_ctrl
  import rcx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        nrst_pin_i,
  output logic        nrst_pull_o,
  output logic        proc_rst_n,
  output logic        wdt_rst_n,
  output logic        periph_rst_n
);
  logic             nrst_lvl, busy, usr_done, swproc_done, cmd_stb;
  rc_cmd_t          cmd;
  logic [LEN_W-1:0] len;

  rcx_sync u_sync (
    .clk   (clk),
    .por_n (por_n),
    .pin_i (nrst_pin_i),
    .lvl_o (nrst_lvl)
  );

  rcx_regs #(.LEN_W(LEN_W)) u_regs (
    .clk         (clk),
    .por_n       (por_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .nrst_lvl    (nrst_lvl),
    .busy        (busy),
    .usr_done    (usr_done),
    .swproc_done (swproc_done),
    .cmd_stb     (cmd_stb),
    .cmd         (cmd),
    .len         (len)
  );

  rcx_seq #(.LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .por_n        (por_n),
    .nrst_lvl     (nrst_lvl),
    .cmd_stb      (cmd_stb),
    .cmd          (cmd),
    .len          (len),
    .proc_rst_n   (proc_rst_n),
    .periph_rst_n (periph_rst_n),
    .wdt_rst_n    (wdt_rst_n),
    .nrst_drive   (nrst_pull_o),
    .busy         (busy),
    .usr_done     (usr_done),
    .swproc_done  (swproc_done)
  );

endmodule

// File: tb/slowclk_rst_ctrl_test.sv
module slowclk_rst_ctrl_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nrst_pull, proc_rst_n, wdt_rst_n, periph_rst_n;
  logic        ext_hold = 1'b0;
  logic        nrst_pin;
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;

  typedef struct {
    int         at;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign nrst_pin = !(nrst_pull || ext_hold);

  slowclk_rst_ctrl uut (
    .clk          (clk),
    .por_n        (por_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .nrst_pin_i   (nrst_pin),
    .nrst_pull_o  (nrst_pull),
    .proc_rst_n   (proc_rst_n),
    .wdt_rst_n    (wdt_rst_n),
    .periph_rst_n (periph_rst_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops the expected profile at mid-cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      logic [4:0] a;
      e = sbq.pop_front();
      a = {proc_rst_n, periph_rst_n, wdt_rst_n, nrst_pull, bus_rdata[8]};
      if (bus_addr != 2'd2) begin
        a[0] = e.v[0];
      end
      if (e.at != cyc) chk({e.tag, " missed slot"}, 32'(e.at), 32'(cyc));
      else             chk(e.tag, {27'd0, a}, {27'd0, e.v});
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc >= 60000) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected<60000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
  endtask

  task automatic drain();
    while (sbq.size() > 0) tick(1);
    tick(2);
  endtask

  function automatic logic [4:0] sw_exp(int k, logic [2:0] b, int s);
    logic p, q, d, bz;
    p  = b[0] && k >= 1 && k <= 2;
    q  = b[1] && k >= 1 && k <= 2;
    d  = b[2] && k >= 1 && k <= s;
    bz = k >= 1 && k <= (b[2] ? s + 3 : 2);
    return {!p, !q, !p, d, bz};
  endfunction

  task automatic push_sw(int c, logic [2:0] b, int s, string tag);
    int e;
    e = b[2] ? s + 3 : 2;
    for (int k = 1; k <= e + 2; k++) sbq.push_back('{c + k, sw_exp(k, b, s), tag});
  endtask

  task automatic push_idle(int c, int n, string tag);
    for (int k = 1; k <= n; k++) sbq.push_back('{c + k, 5'b11100, tag});
  endtask

  task automatic push_usr(int u, int hold, int s, string tag);
    int p;
    logic il, d;
    p = (u + hold > u + 3 + s) ? u + hold : u + 3 + s;
    for (int t = u + 1; t <= p + 6; t++) begin
      il = t >= u + 3 && t <= p + 4;
      d  = t >= u + 3 && t <= u + 2 + s;
      sbq.push_back('{t, {!il, !il, !il, d, 1'b0}, tag});
    end
  endtask

  task automatic sw_cmd(logic [7:0] key, logic [2:0] b, int s, bit accept, string tag);
    if (accept) push_sw(cyc, b, s, tag);
    else        push_idle(cyc, 6, tag);
    bus_write(2'd0, {key, 21'd0, b});
    drain();
  endtask

  task automatic user_rst(int hold, int s, bit collide, string tag);
    int u;
    u = cyc;
    push_usr(u, hold, s, tag);
    ext_hold = 1'b1;
    if (collide) begin
      tick(2);
      bus_write(2'd0, {8'hA5, 21'd0, 3'b001});
    end
    while (cyc < u + hold) begin
      if (cyc == u + 6) chk("R11 pin level bit low", {31'd0, bus_rdata[16]}, 32'd0);
      tick(1);
    end
    ext_hold = 1'b0;
    drain();
  endtask

  task automatic set_len(int l);
    bus_write(2'd1, 32'(l));
    tick(1);
  endtask

  function automatic logic [2:0] stat_type();
    return bus_rdata[2:0];
  endfunction

  initial begin
    tick(3);
    por_n = 1'b1;
    tick(3);
    // R1: state after power-on release
    chk("R1 outputs", {28'd0, proc_rst_n, periph_rst_n, wdt_rst_n, nrst_pull}, 32'hE);
    chk("R1 status", bus_rdata, 32'h0001_0000);
    bus_addr = 2'd1; #1;
    chk("R1 stretch code", bus_rdata, 32'd0);
    bus_addr = 2'd2; tick(1);

    // R3 R4: processor pulse alone, L=0
    set_len(0);
    sw_cmd(8'hA5, 3'b001, 2, 1'b1, "R4 proc pulse");
    chk("R9 type after sw proc", {29'd0, stat_type()}, 32'd3);
    // R3: peripheral alone
    sw_cmd(8'hA5, 3'b010, 2, 1'b1, "R3 periph only");
    chk("R9 type kept after periph", {29'd0, stat_type()}, 32'd3);
    // R3 R5: all three together, L=1 -> 4 cycles
    set_len(1);
    sw_cmd(8'hA5, 3'b111, 4, 1'b1, "R5 all cmds L1");
    // R3: keyed write with no command bits
    sw_cmd(8'hA5, 3'b000, 4, 1'b0, "R3 empty command");
    // R2: wrong key
    sw_cmd(8'h5A, 3'b111, 4, 1'b0, "R2 bad key");
    chk("R2 status unchanged", bus_rdata[8:0], 32'd3);
    // R6: command written while busy is ignored
    push_sw(cyc, 3'b100, 4, "R6 busy ignore");
    bus_write(2'd0, {8'hA5, 21'd0, 3'b100});
    tick(1);
    bus_write(2'd0, {8'hA5, 21'd0, 3'b011});
    drain();
    chk("R6 type unchanged", {29'd0, stat_type()}, 32'd3);
    // R7 R8: user reset held well past the stretch
    user_rst(20, 4, 1'b0, "R8 user long hold");
    chk("R9 type after user", {29'd0, stat_type()}, 32'd4);
    // R5 R8: short outside pulse, stretch L=3 -> 16 cycles
    set_len(3);
    user_rst(2, 16, 1'b0, "R5 user stretch L3");
    // R9: pin-only software pulse keeps type 4
    set_len(0);
    sw_cmd(8'hA5, 3'b100, 2, 1'b1, "R5 sw pin pulse L0");
    chk("R9 type kept after pin-only", {29'd0, stat_type()}, 32'd4);
    // R10: command sampled on the detection edge is discarded
    user_rst(6, 2, 1'b1, "R10 collide");
    chk("R10 type stays user", {29'd0, stat_type()}, 32'd4);
    chk("R11 pin level bit high", {31'd0, bus_rdata[16]}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule